// File: doc/BRIEF.md
# Lane Group Burst Coalescer

A group of 32 lanes issues one memory instruction together. Each lane has an active bit and a byte address of the word it wants. The block takes that instruction and turns the active lanes into the smallest set of burst-aligned memory transactions that covers them. It emits these transactions one per cycle on a valid/ready output. Each transaction carries the burst-aligned address and a 32-bit mask of the lanes it serves, so a later return path can scatter the burst data back to those lanes.

Lanes whose addresses fall in the same aligned burst share one transaction. When the addresses are scattered, each distinct burst gets its own transaction, which in the worst case is one per lane. The burst size is a parameter. The usual values are 16, 32 or 64 bytes, and 64 is the default. The block accepts a new instruction only after every transaction of the current one has been taken by the consumer.

Top module: `warp_coalescer`

## Requirements
- R1: After reset `txValid` is 0 and `inReady` is 1.
- R2: While any transaction of the current instruction has not been handed off, `inReady` is 0 and `inValid` has no effect. `inReady` returns to 1 on the cycle after the last handshake.
- R3: Every emitted `txAddr` has its low log2(BURST_BYTES) bits cleared. It equals the address of each served lane with those bits cleared.
- R4: Lanes whose `inActive` bit is 0 are ignored. Their addresses have no influence, and their `txMask` bit is never set.
- R5: When all active lanes fall in one aligned burst, exactly one transaction is emitted. Its mask equals the active set.
- R6: Each distinct burst touched by the active lanes produces exactly one transaction. The masks of one instruction are disjoint and together equal the active set. Fully scattered lanes give one transaction per active lane.
- R7: Transactions are emitted in order of the lowest-numbered unserved lane. Bit i of `txMask` is lane i, and the lowest set bit of each mask is the lowest lane still pending.
- R8: An accepted instruction with no active lanes produces no transaction, and `inReady` stays 1.
- R9: While `txValid` is 1 and `txReady` is 0, `txValid`, `txAddr` and `txMask` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Block can accept an instruction |
| inActive | input | LANES | Per-lane active bits, bit i is lane i |
| inAddr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| txValid | output | 1 | Transaction available |
| txReady | input | 1 | Consumer takes the transaction |
| txAddr | output | ADDR_W | Burst-aligned address of the transaction |
| txMask | output | LANES | Lanes served by the transaction |

## Verification
The bench targets these cases:
- Instructions that straddle a burst boundary, or start mid-burst. A design with a wrong alignment shift would merge lanes across the boundary or emit an unaligned address.
- Interleaved lanes that alternate between a high and a low burst. A design that orders by address, or picks the wrong lead lane, would emit the low burst first.
- An inactive lane 0 placed in a foreign burst. A design that does not mask inactive lanes would emit an extra transaction.
- An empty instruction and a fully scattered one. These catch a stuck busy flag and a lost lane.
- Back-pressure. This exposes outputs that change, or a new instruction slipping in, while the consumer stalls.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef struct packed {
    logic load;    // capture a new instruction
    logic retire;  // current transaction handed off
  } coal_strobe_t;
endpackage

// File: rtl/coal_ctrl.sv
module coal_ctrl
  import coal_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         txReady,
  input  logic         busy,
  output logic         inReady,
  output coal_strobe_t strobes
);
  assign inReady        = !busy;
  assign strobes.load   = inValid && inReady;
  assign strobes.retire = busy && txReady;

  // R2: no acceptance while transactions remain
  a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.load);
  // R2: a retire in the busy state can only clear, never refill
  a_r2_retire_no_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.retire |-> !strobes.load);
endmodule

// File: rtl/coal_lane_pick.sv
module coal_lane_pick #(
  parameter int LANES = 32,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_datapath.sv
module coal_datapath
  import coal_pkg::*;
#(
  parameter int LANES       = 32,
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 64,
  localparam int OFF_W = $clog2(BURST_BYTES),
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  coal_strobe_t            strobes,
  input  logic [LANES-1:0]        inActive,
  input  logic [LANES*ADDR_W-1:0] inAddr,
  output logic                    busy,
  output logic                    txValid,
  output logic [ADDR_W-1:0]       txAddr,
  output logic [LANES-1:0]        txMask
);
  logic [ADDR_W-1:0]       laneAddr [LANES];
  logic [LANES-1:0]        pending;
  logic [IDX_W-1:0]        leadIdx;
  logic                    leadAny;
  logic [ADDR_W-OFF_W-1:0] leadTag;
  logic [LANES-1:0]        match;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
    end else if (strobes.load) begin
      pending <= inActive;
    end else if (strobes.retire) begin
      pending <= pending & ~match;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) laneAddr[g] <= '0;
        else if (strobes.load) laneAddr[g] <= inAddr[g*ADDR_W +: ADDR_W];
      end
      assign match[g] = pending[g] &&
                        (laneAddr[g][ADDR_W-1:OFF_W] == leadTag);
    end
  endgenerate

  coal_lane_pick #(.LANES(LANES)) i_pick (
    .req (pending),
    .idx (leadIdx),
    .any (leadAny)
  );

  assign leadTag = laneAddr[leadIdx][ADDR_W-1:OFF_W];
  assign busy    = leadAny;
  assign txValid = leadAny;
  assign txAddr  = {leadTag, {OFF_W{1'b0}}};
  assign txMask  = match;

  // R3: lead lane lies inside the emitted burst
  a_r3_lead_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> ((laneAddr[leadIdx] - txAddr) < ADDR_W'(BURST_BYTES)));
  // R6: a valid transaction always serves at least one lane
  a_r6_mask_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txMask != '0));
  // R6: consecutive transactions of one instruction are disjoint
  a_r6_disjoint: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && strobes.retire) |=> ((txMask & $past(txMask)) == '0));
  // R9: stalled transaction holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !strobes.retire) |=>
      (txValid && $stable(txAddr) && $stable(txMask)));
  // R4: served lanes are a subset of the lanes still pending
  a_r4_mask_in_pending: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> ((txMask & ~pending) == '0));
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES       = 32,
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [LANES-1:0]        inActive,
  input  logic [LANES*ADDR_W-1:0] inAddr,
  output logic                    txValid,
  input  logic                    txReady,
  output logic [ADDR_W-1:0]       txAddr,
  output logic [LANES-1:0]        txMask
);
  coal_strobe_t strobes;
  logic         busy;

  coal_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .txReady (txReady),
    .busy    (busy),
    .inReady (inReady),
    .strobes (strobes)
  );

  coal_datapath #(
    .LANES       (LANES),
    .ADDR_W      (ADDR_W),
    .BURST_BYTES (BURST_BYTES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inActive (inActive),
    .inAddr   (inAddr),
    .busy     (busy),
    .txValid  (txValid),
    .txAddr   (txAddr),
    .txMask   (txMask)
  );

  // R2: inReady and txValid are never both high
  a_r2_ready_excl: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !inReady);
  // R3: emitted address is burst aligned
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txAddr % ADDR_W'(BURST_BYTES) == '0));
endmodule

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;
  localparam int LANES = 32;
  localparam int AW    = 32;
  localparam int BB    = 64;

  logic              clk = 0;
  logic              rstN = 0;
  logic              inValid = 0;
  logic              inReady;
  logic [LANES-1:0]  inActive = '0;
  logic [LANES*AW-1:0] inAddr = '0;
  logic              txValid;
  logic              txReady = 0;
  logic [AW-1:0]     txAddr;
  logic [LANES-1:0]  txMask;

  always #5 clk = ~clk;

  warp_coalescer #(.LANES(LANES), .ADDR_W(AW), .BURST_BYTES(BB)) i_warp_coalescer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inActive(inActive), .inAddr(inAddr), .txValid(txValid), .txReady(txReady),
    .txAddr(txAddr), .txMask(txMask));

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] act;
    logic [31:0] base;
    logic [31:0] stride;
    logic [7:0]  nTx;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'd4,    8'd2},  // R6 two bursts
    '{32'hFFFF_FFFF, 32'h0000_0100, 32'd2,    8'd1},  // R5 one burst
    '{32'hFFFF_FFFF, 32'h0000_4000, 32'd64,   8'd32}, // R6 fully scattered
    '{32'h0000_FFFF, 32'h0000_0040, 32'd4,    8'd1},  // R5 half group
    '{32'h0000_0000, 32'h0000_0000, 32'd4,    8'd0},  // R8 empty
    '{32'hFFFF_FFFF, 32'h0000_0020, 32'd4,    8'd3},  // R3 mid-burst start
    '{32'hFFFF_FFFF, 32'h0000_0777, 32'd0,    8'd1},  // R5 same word
    '{32'h8000_0001, 32'h0000_0000, 32'd4096, 8'd2}   // R4 sparse
  };

  logic [AW-1:0]    addrTb [LANES];
  logic [LANES-1:0] actTb;
  logic [AW-1:0]    expAddr [LANES];
  logic [LANES-1:0] expMask [LANES];
  int               expN;

  // Reference list from the requirements: lowest pending lane leads,
  // all pending lanes in its aligned burst join.
  task automatic buildModel();
    logic [LANES-1:0] pend;
    logic [AW-1:0]    tag;
    int               lead;
    pend = actTb;
    expN = 0;
    while (pend != '0) begin
      lead = 0;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
      tag = addrTb[lead] / BB;
      expAddr[expN] = tag * BB;
      expMask[expN] = '0;
      for (int i = 0; i < LANES; i++)
        if (pend[i] && (addrTb[i] / BB == tag)) expMask[expN][i] = 1'b1;
      pend = pend & ~expMask[expN];
      expN++;
    end
  endtask

  task automatic issue(input string req);
    @(negedge clk);
    check(inReady == 1'b1, req, 64'(inReady), 64'd1);
    inActive = actTb;
    for (int i = 0; i < LANES; i++) inAddr[i*AW +: AW] = addrTb[i];
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    buildModel();
  endtask

  task automatic drain(input int expCount, input string req);
    int n = 0;
    while (txValid && n < 40) begin
      if (n < expN) begin
        check(txAddr == expAddr[n], {req, " addr"}, 64'(txAddr), 64'(expAddr[n]));
        check(txMask == expMask[n], {req, " mask"}, 64'(txMask), 64'(expMask[n]));
      end
      check(inReady == 1'b0, "R2 busy", 64'(inReady), 64'd0);
      txReady = 1'b1;
      @(negedge clk);
      n++;
    end
    txReady = 1'b0;
    check(n == expCount, {req, " count"}, 64'(n), 64'(expCount));
    check(inReady == 1'b1 && !txValid, "R2 ready after drain",
          64'({inReady, txValid}), 64'b10);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        finishRun();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txValid == 1'b0, "R1 txValid", 64'(txValid), 64'd0);
    check(inReady == 1'b1, "R1 inReady", 64'(inReady), 64'd1);
    rstN = 1'b1;

    // Table-driven patterns (R3 R5 R6 R7 R8 via model and counts)
    foreach (VECS[v]) begin
      actTb = VECS[v].act;
      for (int i = 0; i < LANES; i++) addrTb[i] = VECS[v].base + AW'(i) * VECS[v].stride;
      issue("R2 accept");
      drain(int'(VECS[v].nTx), $sformatf("R6 vec%0d", v));
    end

    // R7 ordering: even lanes high burst, odd lanes low burst
    actTb = '1;
    for (int i = 0; i < LANES; i++)
      addrTb[i] = (i % 2 == 0) ? 32'h1000 + AW'(i) : 32'h0800 + AW'(i);
    issue("R7 accept");
    check(txAddr == 32'h1000, "R7 first addr", 64'(txAddr), 64'h1000);
    check(txMask == 32'h5555_5555, "R7 first mask", 64'(txMask), 64'h5555_5555);
    drain(2, "R7 order");

    // R4 inactive lane 0 in a foreign burst is ignored
    actTb = 32'hFFFF_FFFE;
    addrTb[0] = 32'h9000;
    for (int i = 1; i < LANES; i++) addrTb[i] = 32'h200 + AW'(i) * 2;
    issue("R4 accept");
    check(txAddr == 32'h200, "R4 addr", 64'(txAddr), 64'h200);
    check(txMask == 32'hFFFF_FFFE, "R4 mask", 64'(txMask), 64'hFFFF_FFFE);
    drain(1, "R4 ignore");

    // R9 back-pressure hold, R2 second offer ignored
    actTb = 32'h0000_000F;
    for (int i = 0; i < LANES; i++) addrTb[i] = 32'h300 + AW'(i) * 64;
    issue("R9 accept");
    begin
      logic [AW-1:0]    a0;
      logic [LANES-1:0] m0;
      a0 = txAddr; m0 = txMask;
      inActive = '1;
      inAddr = '0;
      inValid = 1'b1;   // offer while busy: must have no effect
      repeat (3) @(negedge clk);
      inValid = 1'b0;
      check(txValid == 1'b1, "R9 valid held", 64'(txValid), 64'd1);
      check(txAddr == a0, "R9 addr held", 64'(txAddr), 64'(a0));
      check(txMask == m0, "R9 mask held", 64'(txMask), 64'(m0));
      check(inReady == 1'b0, "R2 not ready while stalled", 64'(inReady), 64'd0);
    end
    drain(4, "R2 offer ignored");

    finishRun();
  end
endmodule